// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder/Decoder

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side it turns every logic-0 bit into a short active-high light pulse. Logic-1 bits and the idle line emit nothing. On the receive side it turns each active-low pulse reported by the transceiver back into a logic-0 bit on the recovered serial line. The framer is outside the block. It supplies one transmit bit per bit cell and consumes the recovered bit. The block shares the framer's 16x oversampling tick.

Two pulse-width modes are offered. In normal mode the pulse is 3/16 of a bit cell, centred in the cell. In low-power mode the pulse is timed by a separate slow reference tick and lasts three of its periods, so its width does not depend on the bit rate. The enable controls decide which medium is active. When the infrared path is active, the wired transmit line is held at the marking level and the wired receive line is ignored. Two loopback variants support self-test. One returns the inverted infrared output to the pulse decoder. The other returns the wired transmit line to the receive output.

Top module: `sir_endec`

## Requirements
- R1: With the infrared path active and normal width selected, a bit-cell phase counter starts at 0 when the path becomes active and advances by one (modulo 16) on each 16x tick. `ir_tx_out` is high exactly while the phase reached on a tick is 7, 8 or 9 and `tx_bit` was 0 at that tick.
- R2: A `tx_bit` of 1 (a logic-1 bit or the idle line) produces no pulse on `ir_tx_out` in either width mode.
- R3: With low-power width selected, `ir_tx_out` rises at the tick that enters phase 7 with `tx_bit` 0. It stays high whatever further 16x ticks arrive, and falls at the third `lp_tick` after that.
- R4: With the infrared path inactive, `ir_tx_out` stays 0 and pulses on `ir_rx_in` have no effect on `rx_bit`. `rx_bit` then follows `ser_rxd`, or `tx_bit` when R9 applies.
- R5: With the infrared path active (`uart_en`=1 and `ir_en`=1), `ser_txd` is held at 1 and `ser_rxd` has no effect on `rx_bit`.
- R6: With `uart_en`=0, `ir_en` has no effect: `ir_tx_out` stays 0 and `ser_txd` follows `tx_bit`. With `ir_en`=0, `ser_txd` also follows `tx_bit`.
- R7: `ir_rx_in` is active low and passes through a two-flop synchronizer. A falling edge drives `rx_bit` to 0 three clock cycles after the input falls. `rx_bit` stays 0 until 16 further 16x ticks have passed. A new falling edge during that time restarts the count of 16.
- R8: With the infrared path active and both `loop_en` and `ir_test` set, the decoder receives the inverted `ir_tx_out` in place of `ir_rx_in`. The block's own pulses then drive `rx_bit` low, and the external `ir_rx_in` is ignored.
- R9: With the infrared path inactive, `loop_en`=1 and `ir_test`=0, `rx_bit` equals `tx_bit` and `ser_rxd` is ignored.
- R10: During and right after reset, `ir_tx_out` is 0, `ser_txd` follows `tx_bit` or is 1 as R5/R6 state, and `rx_bit` is 1 when the infrared path is active and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | Whole-UART enable; when 0 the infrared controls are inert |
| ir_en | input | 1 | Selects the infrared medium instead of the wired line |
| lp_mode | input | 1 | 1 = pulse width set by `lp_tick`, 0 = 3/16 of a bit cell |
| loop_en | input | 1 | Loopback enable |
| ir_test | input | 1 | With `loop_en`, loops the infrared path instead of the wired path |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| lp_tick | input | 1 | One-cycle strobe of the low-power reference |
| tx_bit | input | 1 | Serial transmit bit from the framer |
| ser_rxd | input | 1 | Wired serial receive input |
| ir_rx_in | input | 1 | Transceiver receive input, active low |
| ser_txd | output | 1 | Wired serial transmit output |
| ir_tx_out | output | 1 | Transceiver drive, active-high pulse |
| rx_bit | output | 1 | Recovered serial bit to the framer |

## Verification
A wrong phase count in the encoder shows up at once as a pulse placed in the wrong ticks of the cell. A stuck width counter in low-power mode shows up as a pulse that ends on the wrong reference tick or never ends. A decoder counter that reloads wrongly or decrements on the wrong strobe moves the rising edge of `rx_bit` by whole ticks, which is visible within one bit cell. A bad synchronizer depth moves the falling edge of `rx_bit` by whole clock cycles. A wrong path selection is visible in the same cycle as a wired line that leaves marking, or as a receive output that follows an input it should ignore.

// File: rtl/sir_pkg.sv
package sir_pkg;

  localparam int unsigned SIR_PHASES      = 16;
  localparam int unsigned SIR_WIN_FIRST   = 7;
  localparam int unsigned SIR_WIN_LAST    = 9;
  localparam int unsigned SIR_LP_PERIODS  = 3;
  localparam int unsigned SIR_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    PATH_WIRED = 2'd0,
    PATH_WLOOP = 2'd1,
    PATH_IR    = 2'd2
  } sir_path_e;

  function automatic logic sir_in_window(input int unsigned ph,
                                         input int unsigned first,
                                         input int unsigned last);
    return (ph >= first) && (ph <= last);
  endfunction

  function automatic int unsigned sir_next_phase(input int unsigned ph,
                                                 input int unsigned phases);
    return (ph + 1 >= phases) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/sir_tx_enc.sv
module sir_tx_enc
  import sir_pkg::*;
#(
  parameter int unsigned PHASES    = SIR_PHASES,
  parameter int unsigned WIN_FIRST = SIR_WIN_FIRST,
  parameter int unsigned WIN_LAST  = SIR_WIN_LAST
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick16,
  input  logic tx_bit,
  output logic norm_pulse,
  output logic lp_start
);
  localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_next;
  logic            next_in_win;
  logic            enter_first;

  assign ph_next     = PH_W'(sir_next_phase(32'(ph_q), PHASES));
  assign next_in_win = sir_in_window(32'(ph_next), WIN_FIRST, WIN_LAST);
  assign enter_first = (32'(ph_next) == WIN_FIRST);
  assign lp_start    = active && tick16 && !tx_bit && enter_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= '0;
      norm_pulse <= 1'b0;
    end else if (!active) begin
      ph_q       <= '0;
      norm_pulse <= 1'b0;
    end else if (tick16) begin
      ph_q       <= ph_next;
      norm_pulse <= next_in_win && !tx_bit;
    end
  end

  // R1: a pulse is only ever present while the phase sits in the window
  p_pulse_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    norm_pulse |-> sir_in_window(32'(ph_q), WIN_FIRST, WIN_LAST));

  // R2: a one bit at a tick never leaves a pulse behind it
  p_one_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick16 && tx_bit) |=> !norm_pulse);

  // R1: the phase holds between ticks
  p_phase_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick16) |=> $stable(ph_q));

endmodule

// File: rtl/sir_lp_timer.sv
module sir_lp_timer
  import sir_pkg::*;
#(
  parameter int unsigned LP_PERIODS = SIR_LP_PERIODS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic start,
  input  logic lp_tick,
  output logic lp_pulse
);
  localparam int unsigned CW = $clog2(LP_PERIODS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!active)                    cnt_q <= '0;
    else if (start)                      cnt_q <= CW'(LP_PERIODS);
    else if (lp_tick && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
  end

  assign lp_pulse = (cnt_q != '0);

  // R3: the pulse only begins from a start request
  p_rise_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_pulse) |-> $past(start));

  // R3: without a reference tick the pulse does not end
  p_hold_without_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && lp_pulse && !lp_tick) |=> lp_pulse);

endmodule

// File: rtl/sir_rx_dec.sv
module sir_rx_dec
  import sir_pkg::*;
#(
  parameter int unsigned PHASES      = SIR_PHASES,
  parameter int unsigned SYNC_STAGES = SIR_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick16,
  input  logic ir_in_n,
  output logic rx_low
);
  localparam int unsigned CW = $clog2(PHASES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   fall;
  logic [CW-1:0]          cnt_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sync_q[s] <= 1'b1;
        else if (!active) sync_q[s] <= 1'b1;
        else if (s == 0)  sync_q[s] <= ir_in_n;
        else              sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign fall = prev_q && !sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else if (!active) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      if (fall)                         cnt_q <= CW'(PHASES);
      else if (tick16 && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rx_low = (cnt_q != '0);

  // R7: a detected edge always yields a full bit period of low
  p_edge_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fall) |=> (cnt_q == CW'(PHASES)));

  // R7: the recovered low holds until a tick arrives
  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rx_low && !tick16) |=> rx_low);

  // R4: an inactive decoder reports nothing
  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rx_low);

endmodule

// File: rtl/sir_endec.sv
module sir_endec
  import sir_pkg::*;
#(
  parameter int unsigned PHASES      = SIR_PHASES,
  parameter int unsigned WIN_FIRST   = SIR_WIN_FIRST,
  parameter int unsigned WIN_LAST    = SIR_WIN_LAST,
  parameter int unsigned LP_PERIODS  = SIR_LP_PERIODS,
  parameter int unsigned SYNC_STAGES = SIR_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uart_en,
  input  logic ir_en,
  input  logic lp_mode,
  input  logic loop_en,
  input  logic ir_test,
  input  logic tick16,
  input  logic lp_tick,
  input  logic tx_bit,
  input  logic ser_rxd,
  input  logic ir_rx_in,
  output logic ser_txd,
  output logic ir_tx_out,
  output logic rx_bit
);
  logic      ir_act;
  logic      norm_pulse;
  logic      lp_start;
  logic      lp_pulse;
  logic      dec_in_n;
  logic      rx_low;
  sir_path_e path;

  assign ir_act = uart_en && ir_en;

  always_comb begin
    if (ir_act)                   path = PATH_IR;
    else if (loop_en && !ir_test) path = PATH_WLOOP;
    else                          path = PATH_WIRED;
  end

  sir_tx_enc #(
    .PHASES(PHASES), .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)
  ) u_enc (
    .clk(clk), .rst_n(rst_n), .active(ir_act), .tick16(tick16),
    .tx_bit(tx_bit), .norm_pulse(norm_pulse), .lp_start(lp_start)
  );

  sir_lp_timer #(.LP_PERIODS(LP_PERIODS)) u_lp (
    .clk(clk), .rst_n(rst_n), .active(ir_act), .start(lp_start),
    .lp_tick(lp_tick), .lp_pulse(lp_pulse)
  );

  assign ir_tx_out = ir_act && (lp_mode ? lp_pulse : norm_pulse);
  assign dec_in_n  = (loop_en && ir_test) ? !ir_tx_out : ir_rx_in;

  sir_rx_dec #(.PHASES(PHASES), .SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_n), .active(ir_act), .tick16(tick16),
    .ir_in_n(dec_in_n), .rx_low(rx_low)
  );

  always_comb begin
    ser_txd = tx_bit;
    rx_bit  = ser_rxd;
    unique case (path)
      PATH_IR: begin
        ser_txd = 1'b1;
        rx_bit  = !rx_low;
      end
      PATH_WLOOP: rx_bit = tx_bit;
      default: ;
    endcase
  end

  // R5: infrared medium keeps the wired line marking
  p_mark_when_ir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && ir_en) |-> ser_txd);

  // R4 / R6: no light unless the infrared path is active
  p_dark_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(uart_en && ir_en) |-> !ir_tx_out);

  // R9: wired loopback returns the transmit bit
  p_wired_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(uart_en && ir_en) && loop_en && !ir_test) |-> (rx_bit == tx_bit));

endmodule

// File: tb/sir_endec_bench.sv
module sir_endec_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uart_en = 1'b0, ir_en = 1'b0, lp_mode = 1'b0;
  logic loop_en = 1'b0, ir_test = 1'b0;
  logic tick16 = 1'b0, lp_tick = 1'b0;
  logic tx_bit = 1'b1, ser_rxd = 1'b1, ir_rx_in = 1'b1;
  logic ser_txd, ir_tx_out, rx_bit;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_endec u_sir_endec (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .ir_en(ir_en),
    .lp_mode(lp_mode), .loop_en(loop_en), .ir_test(ir_test),
    .tick16(tick16), .lp_tick(lp_tick), .tx_bit(tx_bit),
    .ser_rxd(ser_rxd), .ir_rx_in(ir_rx_in), .ser_txd(ser_txd),
    .ir_tx_out(ir_tx_out), .rx_bit(rx_bit)
  );

  function automatic logic exp_window(input int k);
    int p;
    p = k % 16;
    return (p >= 7) && (p <= 9);
  endfunction

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) tick16 = 1'b1;
    @(negedge clk) tick16 = 1'b0;
    cyc(4);
  endtask

  task automatic ltick();
    @(negedge clk) lp_tick = 1'b1;
    @(negedge clk) lp_tick = 1'b0;
    cyc(2);
  endtask

  task automatic setup(input logic u, input logic i, input logic lp,
                       input logic lb, input logic t);
    @(negedge clk);
    uart_en = 1'b0; ir_en = 1'b0;
    cyc(2);
    uart_en = u; ir_en = i; lp_mode = lp; loop_en = lb; ir_test = t;
    cyc(2);
  endtask

  task automatic t_reset();
    check("R10", "ir_tx_out in reset", ir_tx_out, 1'b0);
    check("R10", "ser_txd in reset", ser_txd, tx_bit);
    @(negedge clk) rst_n = 1'b1;
    uart_en = 1'b1; ir_en = 1'b1;
    cyc(2);
    check("R10", "rx_bit idle after reset", rx_bit, 1'b1);
    check("R10", "ir_tx_out idle after reset", ir_tx_out, 1'b0);
  endtask

  task automatic t_normal_pulse();
    setup(1, 1, 0, 0, 0);
    tx_bit = 1'b0;
    for (int k = 1; k <= 32; k++) begin
      tick();
      check("R1", $sformatf("pulse after tick %0d", k), ir_tx_out, exp_window(k));
    end
    tx_bit = 1'b1;
  endtask

  task automatic t_one_bits();
    setup(1, 1, 0, 0, 0);
    tx_bit = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      tick();
      check("R2", $sformatf("no pulse for one, tick %0d", k), ir_tx_out, 1'b0);
    end
    setup(1, 1, 1, 0, 0);
    for (int k = 1; k <= 16; k++) tick();
    ltick();
    check("R2", "no low-power pulse for one", ir_tx_out, 1'b0);
  endtask

  task automatic t_lowpower();
    setup(1, 1, 1, 0, 0);
    tx_bit = 1'b0;
    ltick();
    for (int k = 1; k <= 6; k++) tick();
    check("R3", "low before phase 7", ir_tx_out, 1'b0);
    tick();
    check("R3", "rise at phase 7", ir_tx_out, 1'b1);
    tx_bit = 1'b1;
    for (int k = 8; k <= 12; k++) tick();
    check("R3", "held across 16x ticks", ir_tx_out, 1'b1);
    ltick();
    check("R3", "held after first ref tick", ir_tx_out, 1'b1);
    ltick();
    check("R3", "held after second ref tick", ir_tx_out, 1'b1);
    ltick();
    check("R3", "ends at third ref tick", ir_tx_out, 1'b0);
  endtask

  task automatic t_disabled();
    setup(1, 0, 0, 0, 0);
    tx_bit = 1'b0;
    ser_rxd = 1'b1;
    for (int k = 1; k <= 10; k++) tick();
    check("R4", "no light when infrared off", ir_tx_out, 1'b0);
    check("R6", "wired txd follows bit", ser_txd, 1'b0);
    ir_rx_in = 1'b0;
    cyc(4);
    ir_rx_in = 1'b1;
    cyc(2);
    check("R4", "ir input ignored", rx_bit, 1'b1);
    ser_rxd = 1'b0;
    cyc(1);
    check("R4", "rx follows wired input", rx_bit, 1'b0);
    ser_rxd = 1'b1;
    tx_bit = 1'b1;
  endtask

  task automatic t_uart_off();
    setup(0, 1, 0, 0, 0);
    tx_bit = 1'b0;
    for (int k = 1; k <= 10; k++) tick();
    check("R6", "no light with uart off", ir_tx_out, 1'b0);
    check("R6", "wired txd with uart off", ser_txd, 1'b0);
    tx_bit = 1'b1;
    cyc(1);
    check("R6", "wired txd follows one", ser_txd, 1'b1);
  endtask

  task automatic t_mark();
    setup(1, 1, 0, 0, 0);
    tx_bit = 1'b0;
    cyc(1);
    check("R5", "wired txd marking", ser_txd, 1'b1);
    ser_rxd = 1'b0;
    cyc(2);
    check("R5", "wired rxd ignored", rx_bit, 1'b1);
    ser_rxd = 1'b1;
    tx_bit = 1'b1;
  endtask

  task automatic t_decode();
    setup(1, 1, 0, 0, 0);
    tx_bit = 1'b1;
    ir_rx_in = 1'b0;
    cyc(2);
    check("R7", "still high two cycles after edge", rx_bit, 1'b1);
    cyc(1);
    check("R7", "low three cycles after edge", rx_bit, 1'b0);
    ir_rx_in = 1'b1;
    for (int k = 1; k <= 15; k++) tick();
    check("R7", "low after 15 ticks", rx_bit, 1'b0);
    tick();
    check("R7", "high after 16 ticks", rx_bit, 1'b1);
  endtask

  task automatic t_retrigger();
    setup(1, 1, 0, 0, 0);
    ir_rx_in = 1'b0;
    cyc(3);
    ir_rx_in = 1'b1;
    for (int k = 1; k <= 8; k++) tick();
    ir_rx_in = 1'b0;
    cyc(3);
    ir_rx_in = 1'b1;
    for (int k = 1; k <= 15; k++) tick();
    check("R7", "retrigger keeps low", rx_bit, 1'b0);
    tick();
    check("R7", "retrigger ends after 16", rx_bit, 1'b1);
  endtask

  task automatic t_loop_test();
    setup(1, 1, 0, 1, 1);
    ir_rx_in = 1'b0;
    tx_bit = 1'b0;
    for (int k = 1; k <= 6; k++) tick();
    check("R8", "external ir input ignored", rx_bit, 1'b1);
    tick();
    check("R8", "own pulse recovered", rx_bit, 1'b0);
    tick();
    tick();
    tx_bit = 1'b1;
    for (int k = 10; k <= 22; k++) tick();
    check("R8", "still low at tick 22", rx_bit, 1'b0);
    tick();
    check("R8", "high at tick 23", rx_bit, 1'b1);
    ir_rx_in = 1'b1;
  endtask

  task automatic t_wired_loop();
    setup(1, 0, 0, 1, 0);
    ser_rxd = 1'b1;
    tx_bit = 1'b0;
    cyc(1);
    check("R9", "loop returns zero", rx_bit, 1'b0);
    ser_rxd = 1'b0;
    tx_bit = 1'b1;
    cyc(1);
    check("R9", "loop returns one, rxd ignored", rx_bit, 1'b1);
    ser_rxd = 1'b1;
    loop_en = 1'b0;
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_normal_pulse();
    t_one_bits();
    t_lowpower();
    t_disabled();
    t_uart_off();
    t_mark();
    t_decode();
    t_retrigger();
    t_loop_test();
    t_wired_loop();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule